// File: doc/BRIEF.md
# Banked Infrared UART Register File

This block is the host-facing register file of an infrared-capable UART. An 8-bit host bus with a 3-bit offset reaches three register banks. Offset 3 of every bank holds a bank-select register, and the value written there picks the bank that later accesses use. The block stores the baud divisor, a mode register, a legacy control register and an advanced control register. It contains the baud generator, which drives a tick for the serial datapath and a toggling test clock.

Software can program the divisor in two places. One is the legacy divisor pair in bank 1. The other is the advanced divisor pair in bank 2, which only responds while advanced mode is on. Both pairs write one shared divisor. Any read or write of the legacy pair while advanced mode is on forces the block back to legacy mode. This fallback clears the advanced control register. Unless the backward-disable bit is set, it also clears three bits of the legacy control register. The advanced pair never causes a fallback.

Top module: `irbank_regfile`

## Requirements
- R1: After reset, every register reads 0, bank 0 is selected, advanced mode is off, `baud_div` is 0 and `dtr_test` and `irtx_loop_en` are 0.
- R2: A write to offset 3 in any bank selects a new bank. Code 0xA0 selects bank 0, 0xA1 selects bank 1 and 0xA2 selects bank 2. Any other code selects bank 0. Offset 3 reads back 0xA0 plus the bank number.
- R3: In bank 1, offset 0 is the low byte of the divisor and offset 1 is the high byte. Both are written and read there.
- R4: Bank 1 offsets 2 to 7 reach the same registers as bank 0 offsets 2 to 7. Bank 0 offset 2 is the mode register: bit 0 is advanced mode and bit 1 is backward-disable. Offset 4 is the legacy control register, whose bit 4 is loopback. Unused offsets read 0.
- R5: In bank 2 with advanced mode on, offsets 0 and 1 write and read the same shared divisor bytes, and advanced mode stays on.
- R6: In bank 2 with advanced mode off, writes to every offset except 3 are ignored, and those offsets read 0.
- R7: A read or write of bank 1 offset 0 or 1 while advanced mode is on clears advanced mode and the advanced control register on the next clock. A write that causes the fallback still updates the divisor byte.
- R8: During a fallback with backward-disable clear, bits 7, 5 and 0 of the legacy control register are cleared. With backward-disable set, the legacy control register is left unchanged. The backward-disable bit itself is never cleared by a fallback.
- R9: The advanced control register sits at bank 2 offset 2. Its bit 6 always reads 0; the other seven bits store what is written.
- R10: `baud_tick` pulses for one cycle every N clocks, where N is the divisor. A divisor of 0 behaves as 1.
- R11: An internal baud clock toggles on every tick. `dtr_test` carries that clock while bit 7 of the advanced control register is set, and is 0 otherwise.
- R12: `irtx_loop_en` is high exactly when bit 5 of the advanced control register and the loopback bit of the legacy control register are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe; a read counts as an access for fallback |
| addr | input | 3 | Register offset within the selected bank |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| baud_div | output | 16 | Shared divisor as programmed |
| baud_tick | output | 1 | One-cycle tick at the baud rate |
| dtr_test | output | 1 | Baud clock test output |
| irtx_loop_en | output | 1 | Lets the transmitter drive the IR output during loopback |
| adv_mode | output | 1 | Advanced mode is active |

## Verification
The assertions assume that the host never asserts `wr_en` and `rd_en` in the same cycle. They also assume that each strobe lasts one cycle and that `addr` and `wdata` are steady while a strobe is high. The bench issues every access through one write task or one read task. Each task raises exactly one strobe for a single cycle, between falling edges, so the assumption holds throughout the run. The random phase draws offsets and data freely, including bank codes that are not defined. This means the fallback path and the advanced-bank lock are reached from many mixes of register state.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int DIV_W = 2 * DW;

  typedef enum logic [1:0] {
    BANK0 = 2'd0,
    BANK1 = 2'd1,
    BANK2 = 2'd2
  } bank_e;

  localparam logic [3:0] BANK_TAG = 4'hA;

  localparam int OFS_DIV_LO = 0;
  localparam int OFS_DIV_HI = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_BANK   = 3;
  localparam int OFS_LGC    = 4;

  localparam int ADV1_BRCLK = 7;
  localparam int ADV1_RSVD  = 6;
  localparam int ADV1_LOUT  = 5;
  localparam int LGC_LOOP   = 4;

  localparam logic [DW-1:0] LGC_FB_MASK = 8'hA1;

  function automatic bank_e decode_bank(input logic [DW-1:0] code);
    if (code[7:4] == BANK_TAG && code[3:2] == 2'b00 && code[1:0] != 2'b11)
      return bank_e'(code[1:0]);
    return BANK0;
  endfunction

  function automatic logic [DW-1:0] encode_bank(input bank_e b);
    return {BANK_TAG, 2'b00, b};
  endfunction

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
  endfunction
endpackage

// File: rtl/irb_banksel.sv
module irb_banksel
  import irb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output bank_e         cur_bank
);
  logic bank_wr;
  assign bank_wr = wr && (addr == AW'(OFS_BANK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_bank <= BANK0;
    else if (bank_wr) cur_bank <= decode_bank(wdata);
  end

  AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cur_bank != bank_e'(2'd3)); // R2
endmodule

// File: rtl/irb_regs.sv
module irb_regs
  import irb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  bank_e            cur_bank,
  output logic [DIV_W-1:0] div,
  output logic             adv_mode,
  output logic             dis_back,
  output logic [DW-1:0]    lgc_ctl,
  output logic [DW-1:0]    adv_ctl1,
  output logic             fb_evt
);
  logic in_div_ofs, sel_leg_div, sel_adv_div, base_hit;
  logic wr_mode, wr_lgc, wr_adv1, wr_div;

  assign in_div_ofs  = (addr == AW'(OFS_DIV_LO)) || (addr == AW'(OFS_DIV_HI));
  assign sel_leg_div = (cur_bank == BANK1) && in_div_ofs;
  assign sel_adv_div = (cur_bank == BANK2) && adv_mode && in_div_ofs;
  assign base_hit    = (cur_bank == BANK0) || ((cur_bank == BANK1) && !in_div_ofs);
  assign fb_evt      = (wr || rd) && sel_leg_div && adv_mode;

  assign wr_mode = wr && base_hit && (addr == AW'(OFS_CTRL));
  assign wr_lgc  = wr && base_hit && (addr == AW'(OFS_LGC));
  assign wr_adv1 = wr && (cur_bank == BANK2) && adv_mode && (addr == AW'(OFS_CTRL));
  assign wr_div  = wr && (sel_leg_div || sel_adv_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_mode <= 1'b0;
      dis_back <= 1'b0;
    end else if (wr_mode) begin
      adv_mode <= wdata[0];
      dis_back <= wdata[1];
    end else if (fb_evt) begin
      adv_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       adv_ctl1 <= '0;
    else if (fb_evt)  adv_ctl1 <= '0;
    else if (wr_adv1) adv_ctl1 <= wdata & ~(DW'(1) << ADV1_RSVD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lgc_ctl <= '0;
    else if (wr_lgc)              lgc_ctl <= wdata;
    else if (fb_evt && !dis_back) lgc_ctl <= lgc_ctl & ~LGC_FB_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else if (wr_div) begin
      if (addr[0]) div[DIV_W-1:DW] <= wdata;
      else         div[DW-1:0]     <= wdata;
    end
  end

  AST_FB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fb_evt |=> (!adv_mode && adv_ctl1 == '0)); // R7
  AST_DISBACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_evt && dis_back) |=> (lgc_ctl == $past(lgc_ctl) && dis_back)); // R8
  AST_BANK2_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cur_bank == BANK2 && !adv_mode && addr != AW'(OFS_BANK))
      |=> (div == $past(div) && adv_ctl1 == $past(adv_ctl1))); // R6
  AST_ADVDIV_NO_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_adv_div) |=> adv_mode); // R5
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && rd)); // R7
endmodule

// File: rtl/irb_baudgen.sv
module irb_baudgen
  import irb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             br_clk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = eff_div(div) - DIV_W'(1);
  assign tick   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= reload;
    else           cnt <= cnt - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    br_clk <= 1'b0;
    else if (tick) br_clk <= ~br_clk;
  end

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(div) - DIV_W'(1) || ($past(div) == '0 && cnt == '0))); // R10
  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (br_clk != $past(br_clk))); // R11
  AST_CLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(br_clk)); // R11
endmodule

// File: rtl/irbank_regfile.sv
module irbank_regfile
  import irb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [15:0] baud_div,
  output logic        baud_tick,
  output logic        dtr_test,
  output logic        irtx_loop_en,
  output logic        adv_mode
);
  bank_e            cur_bank;
  logic [DIV_W-1:0] div;
  logic             dis_back, fb_evt, br_clk, adv_on;
  logic [DW-1:0]    lgc_ctl, adv_ctl1;

  irb_banksel u_banksel (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .addr(addr), .wdata(wdata),
    .cur_bank(cur_bank)
  );

  irb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .rd(rd_en), .addr(addr),
    .wdata(wdata), .cur_bank(cur_bank), .div(div), .adv_mode(adv_on),
    .dis_back(dis_back), .lgc_ctl(lgc_ctl), .adv_ctl1(adv_ctl1),
    .fb_evt(fb_evt)
  );

  irb_baudgen u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(baud_tick), .br_clk(br_clk)
  );

  function automatic logic [DW-1:0] base_read(input logic [AW-1:0] a);
    case (a)
      AW'(OFS_CTRL): return {{(DW-2){1'b0}}, dis_back, adv_on};
      AW'(OFS_BANK): return encode_bank(cur_bank);
      AW'(OFS_LGC):  return lgc_ctl;
      default:       return '0;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    case (cur_bank)
      BANK1: begin
        if (addr == AW'(OFS_DIV_LO))      rdata = div[DW-1:0];
        else if (addr == AW'(OFS_DIV_HI)) rdata = div[DIV_W-1:DW];
        else                              rdata = base_read(addr);
      end
      BANK2: begin
        if (addr == AW'(OFS_BANK)) rdata = encode_bank(cur_bank);
        else if (adv_on) begin
          case (addr)
            AW'(OFS_DIV_LO): rdata = div[DW-1:0];
            AW'(OFS_DIV_HI): rdata = div[DIV_W-1:DW];
            AW'(OFS_CTRL):   rdata = adv_ctl1;
            default:         rdata = '0;
          endcase
        end
      end
      default: rdata = base_read(addr);
    endcase
  end

  assign baud_div     = div;
  assign adv_mode     = adv_on;
  assign dtr_test     = adv_ctl1[ADV1_BRCLK] & br_clk;
  assign irtx_loop_en = adv_ctl1[ADV1_LOUT] & lgc_ctl[LGC_LOOP];

  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bank == BANK2 && adv_on && addr == AW'(OFS_CTRL)) |-> !rdata[ADV1_RSVD]); // R9
  AST_LOCKED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bank == BANK2 && !adv_on && addr != AW'(OFS_BANK)) |-> rdata == '0); // R6
  AST_FB_DROPS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    fb_evt |=> (!irtx_loop_en && !dtr_test)); // R7
endmodule

// File: tb/sim_irbank_regfile.sv
module sim_irbank_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] baud_div;
  logic baud_tick, dtr_test, irtx_loop_en, adv_mode;

  int checks = 0, failures = 0;

  // bench model
  int   m_bank = 0;
  logic m_adv = 0, m_dis = 0;
  logic [7:0] m_lgc = 0, m_a1 = 0;
  logic [15:0] m_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irbank_regfile u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .baud_div(baud_div), .baud_tick(baud_tick),
    .dtr_test(dtr_test), .irtx_loop_en(irtx_loop_en), .adv_mode(adv_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [7:0] c);
    if (c == 8'hA0) return 0;
    if (c == 8'hA1) return 1;
    if (c == 8'hA2) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic [7:0] code = 8'hA0 + 8'(m_bank);
    if (a == 3) return code;
    if (m_bank == 2) begin
      if (!m_adv) return 8'h00;
      if (a == 0) return m_div[7:0];
      if (a == 1) return m_div[15:8];
      if (a == 2) return m_a1;
      return 8'h00;
    end
    if (m_bank == 1 && a == 0) return m_div[7:0];
    if (m_bank == 1 && a == 1) return m_div[15:8];
    if (a == 2) return {6'b0, m_dis, m_adv};
    if (a == 4) return m_lgc;
    return 8'h00;
  endfunction

  function automatic bit leg_fb(input logic [2:0] a);
    return (m_bank == 1) && (a < 2) && m_adv;
  endfunction

  task automatic model_fb();
    m_adv = 0;
    m_a1  = 0;
    if (!m_dis) m_lgc = m_lgc & 8'h5E;
  endtask

  task automatic model_wr(input logic [2:0] a, input logic [7:0] d);
    bit fb = leg_fb(a);
    if (a == 3) m_bank = bank_of(d);
    else if (m_bank == 2) begin
      if (m_adv) begin
        if (a == 0) m_div[7:0] = d;
        else if (a == 1) m_div[15:8] = d;
        else if (a == 2) m_a1 = d & 8'hBF;
      end
    end else if (m_bank == 1 && a < 2) begin
      if (a == 0) m_div[7:0] = d; else m_div[15:8] = d;
    end else if (a == 2) begin
      m_adv = d[0]; m_dis = d[1];
    end else if (a == 4) m_lgc = d;
    if (fb) model_fb();
  endtask

  task automatic check_outs(input string tag);
    check({tag, " adv_mode"}, adv_mode, m_adv);
    check({tag, " baud_div"}, baud_div, m_div);
    check({tag, " R12 loop"}, irtx_loop_en, m_a1[5] & m_lgc[4]);
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic do_rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 check(tag, rdata, exp_read(a));
    @(posedge clk); #1;
    rd_en = 0;
    if (leg_fb(a)) model_fb();
  endtask

  task automatic tick_period(input int exp, input string tag);
    int n;
    repeat (2) begin
      do @(negedge clk); while (!baud_tick);
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!baud_tick);
    check(tag, n, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 adv", adv_mode, 0);
    check("R1 div", baud_div, 0);
    check("R1 dtr", dtr_test, 0);
    check("R1 loop", irtx_loop_en, 0);
    check("R1 tick every cycle for div 0", baud_tick, 1);
    do_rd(3, "R1 R2 bank reads A0");
    do_rd(2, "R1 mode reg");
    do_rd(4, "R1 lgc reg");

    // R10 divisor 0 and 1 give period 1, 5 gives 5
    tick_period(1, "R10 div0 period");
    do_wr(3, 8'hA1);
    do_rd(3, "R2 bank1 code");
    do_wr(0, 8'd5);
    do_wr(1, 8'd0);
    do_rd(0, "R3 div lo");
    check("R3 div value", baud_div, 16'd5);
    tick_period(5, "R10 div5 period");
    do_wr(0, 8'd1);
    tick_period(1, "R10 div1 period");

    // R4 aliasing: write via bank1, read via bank0
    do_wr(4, 8'hFF);
    do_wr(3, 8'h77);
    do_rd(3, "R2 unknown code -> bank0");
    do_rd(4, "R4 alias lgc");
    check("R4 alias value", rdata, 8'hFF);

    // R6 bank2 locked in legacy mode
    do_wr(3, 8'hA2);
    do_wr(0, 8'h55);
    do_wr(2, 8'hFF);
    do_rd(0, "R6 locked reads 0");
    check("R6 div unchanged", baud_div, 16'd1);

    // R5 advanced divisor, R9 reserved bit
    do_wr(3, 8'hA0);
    do_wr(2, 8'h01);
    do_wr(3, 8'hA2);
    do_wr(0, 8'h03);
    do_wr(1, 8'h00);
    check("R5 adv stays on", adv_mode, 1);
    check("R5 shared div", baud_div, 16'd3);
    do_wr(2, 8'hE0);
    do_rd(2, "R9 adv ctl readback");
    check("R9 bit6 zero", rdata, 8'hA0);
    check_outs("R12 loop on");
    check("R12 loop value", irtx_loop_en, 1);

    // R11 dtr toggles every tick
    for (int k = 0; k < 3; k++) begin
      logic prev;
      do @(negedge clk); while (!baud_tick);
      prev = dtr_test;
      @(negedge clk);
      check("R11 dtr toggles", dtr_test, !prev);
    end
    tick_period(3, "R10 div3 period");

    // R7/R8 fallback, backward-disable clear
    do_wr(3, 8'hA1);
    do_rd(0, "R7 access legacy div");
    check("R7 adv cleared", adv_mode, 0);
    check("R11 dtr off after fallback", dtr_test, 0);
    check("R12 loop off after fallback", irtx_loop_en, 0);
    do_rd(4, "R8 lgc cleared bits");
    check("R8 lgc value", rdata, 8'h5E);

    // R8 backward-disable set
    do_wr(4, 8'hFF);
    do_wr(2, 8'h03);
    do_wr(0, 8'h09);
    check("R7 adv cleared by write", adv_mode, 0);
    check("R7 write still lands", baud_div, 16'd9);
    do_rd(4, "R8 lgc kept");
    check("R8 lgc kept value", rdata, 8'hFF);
    do_rd(2, "R8 disable bit kept");
    check("R8 mode value", rdata, 8'h02);

    // random phase
    begin
      int seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 400; i++) begin
        int op = $urandom_range(0, 9);
        logic [2:0] a = 3'($urandom_range(0, 7));
        logic [7:0] d = 8'($urandom);
        if (op < 2) begin
          case ($urandom_range(0, 3))
            0: d = 8'hA0; 1: d = 8'hA1; 2: d = 8'hA2; default: ;
          endcase
          do_wr(3, d);
        end else if (op < 6) begin
          if (a == 2 && $urandom_range(0, 1) == 1) d[0] = 1'b1;
          do_wr(a, d);
        end else begin
          do_rd(a, "R2 R3 R4 R5 R6 R9 random read");
        end
        @(negedge clk);
        check_outs("R7 R8 random");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule